// File: doc/BRIEF.md
# Effective address generation unit

This unit resolves the operand of an 8-bit processor instruction. It takes an addressing-mode code, the one or two operand bytes that follow the opcode, and the current X and Y index registers. It produces one of four results: no operand, an immediate data byte, a signed branch offset, or a 16-bit effective address. Three modes hold a pointer in memory: indirect, pre-indexed indirect (X is added before the fetch) and post-indexed indirect (Y is added after the fetch). For these three the unit reads two bytes over an 8-bit memory read port and builds the pointer from them. Each result is reported with a type tag and with the number of operand bytes the mode uses. The fetch sequencer can then advance the program counter without a second decode.

A request is a one-cycle `start_i` pulse, sampled together with the mode, the operand bytes and the index registers. The result comes back as a one-cycle `done_o` strobe. `kind_o`, `len_o` and `value_o` are valid while `done_o` is high and hold their values until the next strobe. There is no back-pressure on either side. The consumer must take the result in the strobe cycle. The memory port must return the data for a request in the cycle after that request, and it cannot stall. `busy_o` is high while a pointer fetch is in progress. A `start_i` pulse seen while `busy_o` is high is dropped.

Top module: `ea_gen`

## Requirements
- R1: After reset, and until the first start, `done_o`, `busy_o` and `rd_req_o` are 0.
- R2: Mode codes 0 (accumulator), 1 (implied) and the unused codes 13 to 15 finish with `done_o` in the cycle after the start edge, with kind 0 (none), length 0 and value 0x0000.
- R3: Mode 2 (immediate) gives kind 1 and value {0x00, low byte}. Mode 6 (relative) gives kind 2 and the low byte sign-extended to 16 bits. Both report length 1 and finish in the cycle after the start edge.
- R4: Mode 3 (zero page) gives kind 3 and address {0x00, low byte}. Mode 4 adds X and mode 5 adds Y to the low byte modulo 256, so the high address byte is always 0x00. The length is 1.
- R5: Mode 7 (absolute) gives kind 3 and address {high byte, low byte}, with the first operand byte as the low half. Mode 8 adds X and mode 9 adds Y to that 16-bit value modulo 65536. The length is 2.
- R6: Mode 10 (indirect) reads the byte at P = {high, low} and then the byte at P+1 (a 16-bit increment). It gives kind 3, value {byte at P+1, byte at P} and length 2.
- R7: Mode 11 (pre-indexed) forms P = {0x00, (low + X) mod 256}. It reads at P and then at P+1 as a 16-bit increment, so P = 0x00FF is followed by 0x0100. It gives kind 3, value {byte at P+1, byte at P} and length 1.
- R8: Mode 12 (post-indexed) reads at P = {0x00, low} and then at P+1. It gives kind 3, value ({byte at P+1, byte at P} + Y) mod 65536 and length 1.
- R9: For the pointer modes, the cycle after the start edge carries a read request for P and the next cycle carries a request for P+1. The data for each request is taken one cycle after that request. `done_o` rises three cycles after the start edge, and `busy_o` is high from the start edge until `done_o` rises.
- R10: A start while `busy_o` is high causes no read, no `done_o` and no change to the result in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request pulse |
| mode_i | input | 4 | Addressing-mode code |
| op_lo_i | input | 8 | First operand byte |
| op_hi_i | input | 8 | Second operand byte |
| idx_x_i | input | 8 | X index register |
| idx_y_i | input | 8 | Y index register |
| rd_data_i | input | 8 | Read data, one cycle after the request |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 16 | Read address |
| busy_o | output | 1 | Pointer fetch in progress |
| done_o | output | 1 | Result strobe |
| kind_o | output | 2 | Result type: 0 none, 1 immediate, 2 relative, 3 address |
| len_o | output | 2 | Operand byte count of the mode |
| value_o | output | 16 | Result value |

## Verification
The bench targets the wrap points. These are a zero-page index sum that passes 0xFF, an absolute index sum that passes 0xFFFF, and a pre-indexed pointer at 0x00FF whose second byte lies at 0x0100. A design that carried into the high byte, or that wrapped the pointer increment within page zero, would report the wrong address or read from the wrong location. Pre-indexed and post-indexed modes use different X and Y values, so adding the wrong index, or adding it on the wrong side of the fetch, shows up as a changed address. Starts issued during a fetch must leave no trace, and a unit that accepted them would produce an extra strobe or extra reads. The strobe cycle and the sign extension of a negative relative offset are also checked.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    M_ACC   = 4'd0,
    M_IMP   = 4'd1,
    M_IMM   = 4'd2,
    M_ZP    = 4'd3,
    M_ZPX   = 4'd4,
    M_ZPY   = 4'd5,
    M_REL   = 4'd6,
    M_ABS   = 4'd7,
    M_ABSX  = 4'd8,
    M_ABSY  = 4'd9,
    M_IND   = 4'd10,
    M_PREX  = 4'd11,
    M_POSTY = 4'd12
  } mode_e;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_IMM  = 2'd1,
    K_REL  = 2'd2,
    K_ADDR = 2'd3
  } kind_e;

  function automatic logic needs_fetch(input logic [3:0] m);
    return (m == M_IND) || (m == M_PREX) || (m == M_POSTY);
  endfunction
endpackage

// File: rtl/ea_direct.sv
module ea_direct
  import ea_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]      mode_i,
  input  logic [DW-1:0]   lo_i,
  input  logic [DW-1:0]   hi_i,
  input  logic [DW-1:0]   x_i,
  input  logic [DW-1:0]   y_i,
  output logic [1:0]      kind_o,
  output logic [1:0]      len_o,
  output logic [2*DW-1:0] val_o
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] abs_w;
  logic [DW-1:0] zp_x;
  logic [DW-1:0] zp_y;

  assign abs_w = {hi_i, lo_i};
  assign zp_x  = lo_i + x_i;   // page-zero wrap by width
  assign zp_y  = lo_i + y_i;

  always_comb begin
    kind_o = K_NONE;
    len_o  = 2'd0;
    val_o  = '0;
    case (mode_i)
      M_IMM: begin
        kind_o = K_IMM;  len_o = 2'd1; val_o = {{DW{1'b0}}, lo_i};
      end
      M_REL: begin
        kind_o = K_REL;  len_o = 2'd1; val_o = {{DW{lo_i[DW-1]}}, lo_i};
      end
      M_ZP: begin
        kind_o = K_ADDR; len_o = 2'd1; val_o = {{DW{1'b0}}, lo_i};
      end
      M_ZPX: begin
        kind_o = K_ADDR; len_o = 2'd1; val_o = {{DW{1'b0}}, zp_x};
      end
      M_ZPY: begin
        kind_o = K_ADDR; len_o = 2'd1; val_o = {{DW{1'b0}}, zp_y};
      end
      M_ABS: begin
        kind_o = K_ADDR; len_o = 2'd2; val_o = abs_w;
      end
      M_ABSX: begin
        kind_o = K_ADDR; len_o = 2'd2; val_o = abs_w + {{DW{1'b0}}, x_i};
      end
      M_ABSY: begin
        kind_o = K_ADDR; len_o = 2'd2; val_o = abs_w + {{DW{1'b0}}, y_i};
      end
      default: begin
        kind_o = K_NONE; len_o = 2'd0; val_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/ea_fetch.sv
module ea_fetch
  import ea_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  logic [3:0]      mode_i,
  input  logic [DW-1:0]   lo_i,
  input  logic [DW-1:0]   hi_i,
  input  logic [DW-1:0]   x_i,
  input  logic [DW-1:0]   y_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic            rd_req_o,
  output logic [2*DW-1:0] rd_addr_o,
  output logic            busy_o,
  output logic            fin_o,
  output logic [1:0]      len_o,
  output logic [2*DW-1:0] ptr_o
);
  localparam int AW = 2 * DW;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_WAIT} st_e;

  st_e           st_q;
  logic [AW-1:0] base_q;
  logic [DW-1:0] post_q;
  logic [DW-1:0] lob_q;
  logic          two_q;
  logic [AW-1:0] base_d;
  logic [DW-1:0] pre_sum;

  assign pre_sum = lo_i + x_i;

  always_comb begin
    case (mode_i)
      M_IND:   base_d = {hi_i, lo_i};
      M_PREX:  base_d = {{DW{1'b0}}, pre_sum};
      default: base_d = {{DW{1'b0}}, lo_i};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      base_q <= '0;
      post_q <= '0;
      lob_q  <= '0;
      two_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (go_i) begin
          base_q <= base_d;
          post_q <= (mode_i == M_POSTY) ? y_i : '0;
          two_q  <= (mode_i == M_IND);
          st_q   <= S_LO;
        end
        S_LO:   st_q <= S_HI;
        S_HI: begin
          lob_q <= rd_data_i;
          st_q  <= S_WAIT;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (st_q == S_LO) || (st_q == S_HI);
  assign rd_addr_o = (st_q == S_LO) ? base_q :
                     (st_q == S_HI) ? base_q + AW'(1) : '0;
  assign busy_o    = (st_q != S_IDLE);
  assign fin_o     = (st_q == S_WAIT);
  assign len_o     = two_q ? 2'd2 : 2'd1;
  assign ptr_o     = {rd_data_i, lob_q} + {{DW{1'b0}}, post_q};
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [3:0]          mode_i,
  input  logic [DATA_W-1:0]   op_lo_i,
  input  logic [DATA_W-1:0]   op_hi_i,
  input  logic [DATA_W-1:0]   idx_x_i,
  input  logic [DATA_W-1:0]   idx_y_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  output logic                rd_req_o,
  output logic [2*DATA_W-1:0] rd_addr_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [1:0]          kind_o,
  output logic [1:0]          len_o,
  output logic [2*DATA_W-1:0] value_o
);
  localparam int AW = 2 * DATA_W;

  logic          accept;
  logic          ptr_mode;
  logic [1:0]    dir_kind;
  logic [1:0]    dir_len;
  logic [AW-1:0] dir_val;
  logic          fin;
  logic [1:0]    f_len;
  logic [AW-1:0] f_ptr;

  assign accept   = start_i && !busy_o;
  assign ptr_mode = needs_fetch(mode_i);

  ea_direct #(.DW(DATA_W)) u_direct (
    .mode_i (mode_i),
    .lo_i   (op_lo_i),
    .hi_i   (op_hi_i),
    .x_i    (idx_x_i),
    .y_i    (idx_y_i),
    .kind_o (dir_kind),
    .len_o  (dir_len),
    .val_o  (dir_val)
  );

  ea_fetch #(.DW(DATA_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (accept && ptr_mode),
    .mode_i    (mode_i),
    .lo_i      (op_lo_i),
    .hi_i      (op_hi_i),
    .x_i       (idx_x_i),
    .y_i       (idx_y_i),
    .rd_data_i (rd_data_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .busy_o    (busy_o),
    .fin_o     (fin),
    .len_o     (f_len),
    .ptr_o     (f_ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o  <= 1'b0;
      kind_o  <= K_NONE;
      len_o   <= 2'd0;
      value_o <= '0;
    end else if (fin) begin
      done_o  <= 1'b1;
      kind_o  <= K_ADDR;
      len_o   <= f_len;
      value_o <= f_ptr;
    end else if (accept && !ptr_mode) begin
      done_o  <= 1'b1;
      kind_o  <= dir_kind;
      len_o   <= dir_len;
      value_o <= dir_val;
    end else begin
      done_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy_o,
  input logic            done_o,
  input logic [1:0]      kind_o,
  input logic [1:0]      len_o,
  input logic [2*DW-1:0] value_o,
  input logic            rd_req_o,
  input logic [2*DW-1:0] rd_addr_o
);
  localparam int AW = 2 * DW;

  logic       busy_q;
  logic [2:0] rise_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rise_sh <= '0;
    end else begin
      busy_q  <= busy_o;
      rise_sh <= {rise_sh[1:0], busy_o && !busy_q};
    end
  end

  // R9: reads only happen during a fetch
  a_r9_req_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> busy_o);

  // R6: the second request addresses the byte after the first
  a_r6_second_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && $past(rd_req_o)) |-> (rd_addr_o == $past(rd_addr_o) + AW'(1)));

  // R9: the strobe follows three cycles after a fetch begins
  a_r9_fetch_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rise_sh[2] |-> done_o);

  // R9: a strobe that ends a fetch carries an address
  a_r9_fetch_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(busy_o)) |-> (kind_o == 2'd3));

  // R2: no operand means zero length and zero value
  a_r2_none_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && kind_o == 2'd0) |-> (len_o == 2'd0 && value_o == '0));

  // R3: relative offsets are sign-extended, one operand byte
  a_r3_rel_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && kind_o == 2'd2) |-> (value_o[AW-1:DW] == {DW{value_o[DW-1]}} && len_o == 2'd1));
endmodule

bind ea_gen ea_gen_chk #(.DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .kind_o    (kind_o),
  .len_o     (len_o),
  .value_o   (value_o),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o)
);

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [7:0]  op_lo_i = '0, op_hi_i = '0, idx_x_i = '0, idx_y_i = '0;
  logic [7:0]  rd_data_i = '0;
  logic        rd_req_o, busy_o, done_o;
  logic [15:0] rd_addr_o, value_o;
  logic [1:0]  kind_o, len_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  logic [19:0] res_q[$];
  string       res_tag_q[$];
  logic [15:0] rd_q[$];
  string       rd_tag_q[$];

  always #10 clk = ~clk;

  ea_gen uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .op_lo_i(op_lo_i), .op_hi_i(op_hi_i), .idx_x_i(idx_x_i), .idx_y_i(idx_y_i),
    .rd_data_i(rd_data_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .busy_o(busy_o), .done_o(done_o), .kind_o(kind_o), .len_o(len_o),
    .value_o(value_o)
  );

  function automatic logic [7:0] memb(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd3;
    return t ^ a[15:8] ^ 8'hA5;
  endfunction

  // memory model: data one cycle after a request
  always @(posedge clk) rd_data_i <= rd_req_o ? memb(rd_addr_o) : 8'h00;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] x, input logic [7:0] y, input string tag);
    logic [1:0]  k, l;
    logic [15:0] v, p;
    logic [7:0]  s;
    bit          ptr;
    ptr = 0; k = 2'd0; l = 2'd0; v = 16'h0; p = 16'h0;
    case (m)
      4'd2:  begin k = 2'd1; l = 2'd1; v = {8'h00, lo}; end
      4'd6:  begin k = 2'd2; l = 2'd1; v = {{8{lo[7]}}, lo}; end
      4'd3:  begin k = 2'd3; l = 2'd1; v = {8'h00, lo}; end
      4'd4:  begin s = lo + x; k = 2'd3; l = 2'd1; v = {8'h00, s}; end
      4'd5:  begin s = lo + y; k = 2'd3; l = 2'd1; v = {8'h00, s}; end
      4'd7:  begin k = 2'd3; l = 2'd2; v = {hi, lo}; end
      4'd8:  begin k = 2'd3; l = 2'd2; v = {hi, lo} + {8'h00, x}; end
      4'd9:  begin k = 2'd3; l = 2'd2; v = {hi, lo} + {8'h00, y}; end
      4'd10: begin ptr = 1; l = 2'd2; p = {hi, lo}; end
      4'd11: begin ptr = 1; l = 2'd1; s = lo + x; p = {8'h00, s}; end
      4'd12: begin ptr = 1; l = 2'd1; p = {8'h00, lo}; end
      default: ;
    endcase
    if (ptr) begin
      k = 2'd3;
      v = {memb(p + 16'd1), memb(p)};
      if (m == 4'd12) v = v + {8'h00, y};
      rd_q.push_back(p);          rd_tag_q.push_back({tag, " read lo"});
      rd_q.push_back(p + 16'd1);  rd_tag_q.push_back({tag, " read hi"});
    end
    @(negedge clk);
    while (busy_o) @(negedge clk);
    mode_i = m; op_lo_i = lo; op_hi_i = hi; idx_x_i = x; idx_y_i = y;
    start_i = 1'b1;
    res_q.push_back({k, l, v});
    res_tag_q.push_back(tag);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // scoreboard monitor
  logic [19:0] e_res;
  logic [15:0] e_rd;
  string       e_tag;
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (done_o) begin
        checks++;
        if (res_q.size() == 0) begin
          fails++;
          $display("FAIL R10 unexpected done: actual kind=%0d value=%h expected no strobe", kind_o, value_o);
        end else begin
          e_res = res_q.pop_front();
          e_tag = res_tag_q.pop_front();
          if ({kind_o, len_o, value_o} !== e_res) begin
            fails++;
            $display("FAIL %s actual kind=%0d len=%0d value=%h expected kind=%0d len=%0d value=%h",
                     e_tag, kind_o, len_o, value_o, e_res[19:18], e_res[17:16], e_res[15:0]);
          end
        end
      end
      if (rd_req_o) begin
        checks++;
        if (rd_q.size() == 0) begin
          fails++;
          $display("FAIL R10 unexpected read: actual addr=%h expected no read", rd_addr_o);
        end else begin
          e_rd  = rd_q.pop_front();
          e_tag = rd_tag_q.pop_front();
          if (rd_addr_o !== e_rd) begin
            fails++;
            $display("FAIL %s actual addr=%h expected addr=%h", e_tag, rd_addr_o, e_rd);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 done after reset", {31'b0, done_o}, 32'd0);
    check("R1 busy after reset", {31'b0, busy_o}, 32'd0);
    check("R1 read after reset", {31'b0, rd_req_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {29'b0, done_o, busy_o, rd_req_o}, 32'd0);

    issue(4'd0, 8'h12, 8'h34, 8'h01, 8'h02, "R2 accumulator");
    check("R2 strobe in cycle after start", {31'b0, done_o}, 32'd1);
    issue(4'd1, 8'hFF, 8'hFF, 8'h00, 8'h00, "R2 implied");
    issue(4'd14, 8'h55, 8'hAA, 8'h00, 8'h00, "R2 unused code");

    issue(4'd2, 8'h9C, 8'h00, 8'h00, 8'h00, "R3 immediate");
    check("R3 strobe in cycle after start", {31'b0, done_o}, 32'd1);
    issue(4'd6, 8'h80, 8'h00, 8'h00, 8'h00, "R3 relative negative");
    issue(4'd6, 8'h7F, 8'h00, 8'h00, 8'h00, "R3 relative positive");

    issue(4'd3, 8'h44, 8'h99, 8'h00, 8'h00, "R4 zero page");
    issue(4'd4, 8'hF0, 8'h00, 8'h20, 8'h03, "R4 zero page X wrap");
    issue(4'd5, 8'h10, 8'h00, 8'h40, 8'h05, "R4 zero page Y");
    issue(4'd5, 8'hFF, 8'h00, 8'h00, 8'h01, "R4 zero page Y wrap");

    issue(4'd7, 8'h34, 8'h12, 8'h00, 8'h00, "R5 absolute");
    issue(4'd8, 8'hFF, 8'h12, 8'h01, 8'h77, "R5 absolute X page cross");
    issue(4'd9, 8'hF0, 8'hFF, 8'h08, 8'h20, "R5 absolute Y wrap");

    issue(4'd10, 8'h00, 8'h20, 8'h00, 8'h00, "R6 indirect");
    n = 0;
    while (!done_o && n < 10) begin @(negedge clk); n++; end
    check("R9 fetch strobe three cycles after start", n, 32'd3);
    issue(4'd10, 8'hFF, 8'h30, 8'h11, 8'h22, "R6 indirect across page");

    issue(4'd11, 8'hFE, 8'h00, 8'h01, 8'h50, "R7 pre-indexed pointer at 00FF");
    issue(4'd11, 8'h80, 8'h00, 8'h90, 8'h01, "R7 pre-indexed wrap");

    issue(4'd12, 8'h40, 8'h00, 8'h03, 8'hFF, "R8 post-indexed");
    // R10: starts while busy are dropped
    check("R10 busy during fetch", {31'b0, busy_o}, 32'd1);
    mode_i = 4'd2; op_lo_i = 8'hEE; start_i = 1'b1;
    @(negedge clk);
    mode_i = 4'd10;
    @(negedge clk);
    start_i = 1'b0;
    issue(4'd12, 8'hFF, 8'h00, 8'h00, 8'h80, "R8 post-indexed pointer at 00FF");
    issue(4'd2, 8'h01, 8'h00, 8'h00, 8'h00, "R10 first start after fetch");

    repeat (6) @(negedge clk);
    check("R10 no pending results", res_q.size(), 32'd0);
    check("R9 no pending reads", rd_q.size(), 32'd0);
    ended = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule